// File: doc/BRIEF.md
# Configurable Stereo Serial Audio Receiver

This block takes stereo PCM audio arriving bit-serially and turns each stereo frame into a pair of parallel 20-bit two's-complement words, one per channel, announced by a single-cycle strobe. A bit clock and a word clock arrive from an external timing source. Both are sampled by the block's system clock, so the block works in one clock domain and needs the system clock to run at least four times faster than the bit clock.

A three-bit mode input chooses the wire layout and the sample length. In the dual-pin layout each channel has its own data pin and both are shifted in parallel. In the single-pin layout one pin carries the left word followed by the right word. Shorter samples are left-aligned in the 20-bit outputs, with zeros in the unused low bits, so the full-scale range stays the same at every resolution. Two mode codes are reserved for test: while either is selected, a flag is raised and no samples are issued.

Top module: `stereo_serial_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `left_o` and `right_o` are zero and `valid_o` and `test_o` are low.
- R2: A frame starts at the first bit-clock rising edge where the word clock is sampled low, provided it was sampled high at the previous bit-clock rising edge. Data bits are sampled on bit-clock rising edges, most significant bit first, starting with that edge.
- R3: Mode codes 3'b000, 3'b001 and 3'b010 select the dual-pin layout with 16-, 18- and 20-bit samples. The left word is shifted in from `sd_a_i` and the right word from `sd_b_i` on the same edges.
- R4: Mode codes 3'b100, 3'b101 and 3'b110 select the single-pin layout with 16-, 18- and 20-bit samples. On `sd_a_i` the left word comes first and the right word follows immediately. `sd_b_i` is ignored.
- R5: A sample of N bits is placed in the top N bits of its 20-bit output and the low 20-N bits are zero. For example, the 16-bit word 0x8001 appears as 0x80010.
- R6: When the last bit of a frame is taken, both outputs update on the same clock and `valid_o` is high for exactly that one clock cycle. At all other times the outputs hold their values.
- R7: Whenever the two low mode bits are both 1 (codes 3'b011 and 3'b111), `test_o` is high one clock later. Frames that finish while a test code is applied raise no `valid_o` and leave the outputs unchanged.
- R8: If a new frame start arrives before a frame is complete, the partial frame is discarded. Bits that arrive after a frame completes are ignored until the next frame start.
- R9: The layout and resolution are taken from the mode input at the frame-start edge. A change to a non-test code in the middle of a frame does not alter how that frame is assembled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Layout (bit 2) and resolution/test code (bits 1:0) |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock; a falling level marks a frame start |
| sd_a_i | input | 1 | Left data in dual-pin layout; both channels in single-pin layout |
| sd_b_i | input | 1 | Right data in dual-pin layout |
| left_o | output | 20 | Left sample, left-aligned two's complement |
| right_o | output | 20 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe when a stereo pair is updated |
| test_o | output | 1 | High while a test mode code is applied |

## Verification
The assertions assume that the bit clock and word clock are already synchronous to the system clock. They also assume that each bit-clock level lasts at least two system clocks, so that two bit-clock rising edges can never land on adjacent cycles. The stimulus keeps to this: it changes every serial input on the falling system clock edge and holds each bit-clock phase for two cycles. Between frames the stimulus always spends one bit period with the word clock high, so that every frame it sends has a proper start. It also changes the mode only at frame boundaries, except in the deliberate mid-frame case, where the new code is not a test code.

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sd_a_i,
  input  logic              sd_b_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              test_o
);
  localparam int CW = $clog2(2 * WORD_W + 1);

  logic              bclk_q, wclk_q, busy;
  logic [2:0]        mode_q;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sh_l, sh_r;

  function automatic logic [CW-1:0] res_of(input logic [1:0] r);
    case (r)
      2'b00:   return CW'(WORD_W - 4);
      2'b01:   return CW'(WORD_W - 2);
      default: return CW'(WORD_W);
    endcase
  endfunction

  wire rise      = bclk_i & ~bclk_q;
  wire wfall     = rise & wclk_q & ~wclk_i;
  wire live_test = &mode_i[1:0];
  wire [2:0] cur = wfall ? mode_i : mode_q;
  wire go        = wfall ? ~live_test : busy;
  wire single    = cur[2];

  wire [CW-1:0] idx  = wfall ? '0 : cnt;
  wire [CW-1:0] nres = res_of(cur[1:0]);
  wire [CW-1:0] last = single ? ((nres << 1) - 1'b1) : (nres - 1'b1);
  wire [CW-1:0] pad  = CW'(WORD_W) - nres;

  wire to_right = single & (idx >= nres);
  wire take_l   = go & rise & ~to_right;
  wire take_r   = go & rise & (~single | to_right);
  wire done     = go & rise & (idx == last);
  wire bit_r    = single ? sd_a_i : sd_b_i;

  wire [WORD_W-1:0] nl = {sh_l[WORD_W-2:0], sd_a_i};
  wire [WORD_W-1:0] nr = {sh_r[WORD_W-2:0], bit_r};
  wire [WORD_W-1:0] cl = take_l ? nl : sh_l;
  wire [WORD_W-1:0] cr = take_r ? nr : sh_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      wclk_q  <= 1'b0;
      busy    <= 1'b0;
      mode_q  <= '0;
      cnt     <= '0;
      sh_l    <= '0;
      sh_r    <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
      test_o  <= 1'b0;
    end else begin
      bclk_q  <= bclk_i;
      valid_o <= 1'b0;
      test_o  <= live_test;
      if (rise) begin
        wclk_q <= wclk_i;
        busy   <= go & ~done;
      end
      if (wfall) mode_q <= mode_i;
      if (go & rise) cnt <= idx + 1'b1;
      if (take_l) sh_l <= nl;
      if (take_r) sh_r <= nr;
      if (done & ~live_test) begin
        left_o  <= cl << pad;
        right_o <= cr << pad;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

module stereo_serial_rx_chk #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic [2:0]        mode_q,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              valid_o,
  input logic              test_o
);
  localparam logic [WORD_W-1:0] M16 = (WORD_W'(1) << (WORD_W - 16)) - 1'b1;
  localparam logic [WORD_W-1:0] M18 = (WORD_W'(1) << (WORD_W - 18)) - 1'b1;

  // R6
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R7
  test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_o |-> !valid_o);

  // R7
  test_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (test_o == ($past(mode_i[1:0]) == 2'b11)));

  // R5
  pad16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_q[1:0] == 2'b00) |-> (((left_o | right_o) & M16) == '0));

  // R5
  pad18_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_q[1:0] == 2'b01) |-> (((left_o | right_o) & M18) == '0));
endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_q(mode_q),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .test_o(test_o)
);

// File: tb/stereo_serial_rx_bench.sv
module stereo_serial_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic bclk = 1'b0, wclk = 1'b1, sd_a = 1'b0, sd_b = 1'b0;
  logic [19:0] left, right;
  logic valid, test;
  int n_tests = 0, n_fail = 0, vcount = 0;

  always #10 clk = ~clk;

  stereo_serial_rx u_stereo_serial_rx (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bclk_i(bclk), .wclk_i(wclk),
    .sd_a_i(sd_a), .sd_b_i(sd_b), .left_o(left), .right_o(right),
    .valid_o(valid), .test_o(test)
  );

  // behavioural reference model
  int qa[$], qb[$];
  logic mb = 1'b0, mw = 1'b0, act = 1'b0;
  logic [2:0] mm = 3'b000;
  logic [19:0] el = '0, er = '0;
  logic ev = 1'b0, et = 1'b0;

  function automatic logic [19:0] pack(int q[$], int n);
    logic [19:0] v = '0;
    foreach (q[i]) v = (v << 1) | 20'(q[i]);
    return v << (20 - n);
  endfunction

  always @(posedge clk) begin
    ev <= 1'b0;
    et <= (mode[1:0] == 2'b11);
    mb <= bclk;
    if (rst_n && bclk && !mb) begin
      int n;
      mw <= wclk;
      if (mw && !wclk) begin
        qa = {}; qb = {}; mm = mode; act = (mode[1:0] != 2'b11);
      end
      n = (mm[1:0] == 2'b00) ? 16 : (mm[1:0] == 2'b01) ? 18 : 20;
      if (act) begin
        if (!mm[2]) begin qa.push_back(int'(sd_a)); qb.push_back(int'(sd_b)); end
        else if (qa.size() < n) qa.push_back(int'(sd_a));
        else qb.push_back(int'(sd_a));
        if (qb.size() == n) begin
          act = 1'b0;
          if (mode[1:0] != 2'b11) begin
            el <= pack(qa, n); er <= pack(qb, n); ev <= 1'b1;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_tests++;
    if (valid !== ev || left !== el || right !== er || test !== et) begin
      n_fail++;
      $display("FAIL R6/R7 model: valid=%b/%b left=%h/%h right=%h/%h test=%b/%b",
               valid, ev, left, el, right, er, test, et);
    end
    if (valid) vcount++;
  end

  task automatic chk(input string tag, input logic [19:0] a, input logic [19:0] e);
    n_tests++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [2:0] m2, input int sw,
                      input logic [63:0] a, input logic [63:0] b, input int len, input int nb);
    mode = m;
    wclk = 1'b1; bclk = 1'b0; sd_a = 1'b0; sd_b = 1'b0;
    repeat (2) @(negedge clk); bclk = 1'b1; repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i == sw) mode = m2;
      bclk = 1'b0; wclk = 1'b0;
      sd_a = (i < len) ? a[len-1-i] : 1'b1;
      sd_b = (i < len) ? b[len-1-i] : 1'b1;
      repeat (2) @(negedge clk); bclk = 1'b1; repeat (2) @(negedge clk);
    end
    bclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    chk("R1 left", left, 20'h0); chk("R1 right", right, 20'h0);
    chk("R1 valid", 20'(valid), 20'h0); chk("R1 test", 20'(test), 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 left after release", left, 20'h0);
    chk("R1 valid after release", 20'(valid), 20'h0);

    v0 = vcount;
    send(3'b010, 3'b010, 99, 64'h7FFFF, 64'h80000, 20, 20);
    chk("R3 R2 dual20 left", left, 20'h7FFFF); chk("R3 dual20 right", right, 20'h80000);
    chk("R6 one strobe", 20'(vcount - v0), 20'd1);

    send(3'b000, 3'b000, 99, 64'h8001, 64'h1234, 16, 16);
    chk("R5 R3 dual16 left", left, 20'h80010); chk("R5 dual16 right", right, 20'h12340);

    send(3'b001, 3'b001, 99, 64'h2AAAB, 64'h00001, 18, 18);
    chk("R5 R3 dual18 left", left, 20'hAAAAC); chk("R5 dual18 right", right, 20'h00004);

    send(3'b110, 3'b110, 99, {24'h0, 20'h12345, 20'hFEDCB}, 64'hFFFFFFFFFF, 40, 40);
    chk("R4 single20 left", left, 20'h12345); chk("R4 single20 right", right, 20'hFEDCB);

    send(3'b100, 3'b100, 99, {32'h0, 16'hBEEF, 16'h0042}, 64'h0, 32, 32);
    chk("R4 R5 single16 left", left, 20'hBEEF0); chk("R4 R5 single16 right", right, 20'h00420);

    send(3'b101, 3'b101, 99, {28'h0, 18'h3FFFF, 18'h20000}, 64'h0, 36, 36);
    chk("R4 R5 single18 left", left, 20'hFFFFC); chk("R4 R5 single18 right", right, 20'h80000);

    v0 = vcount;
    send(3'b011, 3'b011, 99, 64'h11111, 64'h22222, 20, 20);
    chk("R7 test flag 011", 20'(test), 20'h1);
    send(3'b111, 3'b111, 99, {24'h0, 20'h33333, 20'h44444}, 64'h0, 40, 40);
    chk("R7 test flag 111", 20'(test), 20'h1);
    chk("R7 no strobe in test", 20'(vcount - v0), 20'h0);
    chk("R7 left held", left, 20'hFFFFC); chk("R7 right held", right, 20'h80000);

    v0 = vcount;
    send(3'b010, 3'b010, 99, 64'hFFFFF, 64'hFFFFF, 20, 10);
    chk("R7 test flag cleared", 20'(test), 20'h0);
    chk("R8 partial no strobe", 20'(vcount - v0), 20'h0);
    send(3'b010, 3'b010, 99, 64'h00ABC, 64'h00DEF, 20, 20);
    chk("R8 restart left", left, 20'h00ABC); chk("R8 restart right", right, 20'h00DEF);

    v0 = vcount;
    send(3'b000, 3'b000, 99, 64'h5A5A, 64'hA5A5, 16, 24);
    chk("R8 trailing bits ignored left", left, 20'h5A5A0);
    chk("R8 trailing bits ignored right", right, 20'hA5A50);
    chk("R8 single strobe", 20'(vcount - v0), 20'h1);

    send(3'b000, 3'b110, 5, 64'h7001, 64'h0FF0, 16, 16);
    chk("R9 mid-frame mode left", left, 20'h70010);
    chk("R9 mid-frame mode right", right, 20'h0FF00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule